// File: doc/BRIEF.md
# Seconds Counter with Oscillator Gating

This block keeps elapsed time as a free-running 32-bit binary count of seconds. It is clocked directly by a 32.768 kHz timebase. A 15-bit prescaler divides that timebase into one enable pulse per second, and the pulse advances the count. Software turns the count into a calendar date; the block only counts.

Software reaches the count through a byte-wide register port. The four count bytes sit at addresses 0 to 3, lowest byte first. A control byte at address 4 carries a stop bit.

- Reads are kept coherent by a snapshot. Reading byte 0 freezes all four bytes, so a carry between byte reads cannot tear the value.
- Writes are kept coherent by a staging register. Byte writes collect there during a write frame. The whole value is loaded into the count, and the prescaler is cleared, when the frame closes.

A backup-mode input sets what the stop bit does:
- On main power the timebase always runs, and the stop bit only freezes the count.
- In backup mode the stop bit also halts the timebase and signals a low-power standby state.

Top module: `sec_counter_top`

## Requirements
- R1: After reset the count is 0, the stop bit is 0 (counting enabled) and the read data output is 0.
- R2: The running timebase produces one tick every 2^PRE_W clock cycles. While the stop bit is 0, each tick adds one to the count. After a load, the first increment comes exactly 2^PRE_W cycles after the load edge.
- R3: The control register is at address 4, and its bit 7 is the stop bit. While the stop bit is 1 the count does not change. Bits 6..0 always read 0, and writes to them have no effect.
- R4: On main power (`backup_mode`=0) the timebase runs whatever the stop bit says (`osc_run`=1). In backup mode with the stop bit at 1, `osc_run`=0, `standby`=1 and the prescaler holds its value. In backup mode with the stop bit at 0, the block counts as on main power.
- R5: Count byte k (k = 0..3) is at address k. Address 0 holds bits 7..0 and address 3 holds bits 31..24.
- R6: A read of address 0 returns the low byte and captures all 32 count bits. Later reads of addresses 1..3 return bytes of that captured value, even if the live count has moved on.
- R7: Writes take effect only while `reg_sel`=1. A write to addresses 0..3 changes a staging copy. That copy is initialised from the count when `reg_sel` rises. The live count is unchanged until `reg_sel` falls. At that edge the count takes the staged value and the prescaler restarts from 0. Bytes that were not written keep their captured value.
- R8: The count wraps from FFFFFFFFh to 00000000h with no other effect.
- R9: Read data appears on `reg_rdata` one cycle after a `reg_rd` strobe and holds until the next strobe. Reads of addresses 5..7 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| backup_mode | input | 1 | 1 when running from the backup supply |
| reg_sel | input | 1 | Frames a write transaction; its falling edge commits staged count bytes |
| reg_wr | input | 1 | Write strobe, honoured only while reg_sel is 1 |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| osc_run | output | 1 | Timebase running |
| standby | output | 1 | Low-power standby (backup mode with the stop bit set) |

## Verification
Several rules are checked by assertions on every cycle:
- the prescaler advances by one when running, holds when halted, and returns to zero on a load;
- the count steps by exactly one per enabled tick, wrap included;
- a commit copies the staged value;
- the count holds while stopped;
- read data holds between strobes.

Other behaviour can only be shown by the bench's scenarios:
- the exact cycle of the first increment after a load;
- the torn-read case, where a carry lands between the low-byte read and the later byte reads;
- staged bytes staying invisible until the frame closes;
- the byte-lane sweep against an arithmetic model.

// File: rtl/sc_pkg.sv
// Package: shared byte type and default geometry of the seconds counter.
// Assumes: count width is a multiple of 8.
package sc_pkg;
    typedef logic [7:0] byte_t;
    localparam int DEF_CNT_W     = 32;
    localparam int DEF_PRE_W     = 15;
    localparam int DEF_ADDR_W    = 3;
    localparam int DEF_CTRL_ADDR = 4;
    localparam int DEF_STOP_BIT  = 7;
endpackage

// File: rtl/sc_prescaler.sv
// Module: sc_prescaler
// Divides the timebase by 2^PRE_W and emits a one-cycle tick on rollover.
// Assumes: clr has priority over run; the tick is suppressed in the clearing cycle.
module sc_prescaler #(
    parameter int PRE_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam logic [PRE_W-1:0] PRE_MAX = '1;

    logic [PRE_W-1:0] pre;

    // Advance the divider while the timebase runs; restart on a count load.
    always_ff @(posedge clk) begin
        if (!rst_n)   pre <= '0;
        else if (clr) pre <= '0;
        else if (run) pre <= pre + 1'b1;
    end

    assign tick = run && !clr && (pre == PRE_MAX);

    // R2
    pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (pre == $past(pre) + 1'b1));
    // R4
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(pre));
    // R7
    pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre == '0));
endmodule

// File: rtl/sc_count_core.sv
// Module: sc_count_core
// Holds the live seconds count and the staging copy used by write frames.
// Assumes: wr is already qualified by sel; a commit happens on the first cycle
// after sel falls, if any count byte was written in the frame.
module sc_count_core #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              count_en,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  sc_pkg::byte_t     wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic              load
);
    localparam int NBYTES = CNT_W / 8;

    logic             sel_q;
    logic             pend;
    logic [CNT_W-1:0] stage;
    logic [CNT_W-1:0] stage_base;
    logic [CNT_W-1:0] stage_nxt;
    logic             wr_cnt;

    assign stage_base = (sel && !sel_q) ? cnt : stage;
    assign wr_cnt     = wr && ({1'b0, addr} < (ADDR_W+1)'(NBYTES));
    assign load       = sel_q && !sel && pend;

    // Per-lane staging merge: the addressed lane takes write data.
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign stage_nxt[8*i +: 8] = (wr && addr == ADDR_W'(i))
                                     ? wdata : stage_base[8*i +: 8];
    end

    // Track the frame edge and whether the frame touched the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            sel_q <= sel;
            if (load)        pend <= 1'b0;
            else if (wr_cnt) pend <= 1'b1;
        end
    end

    // Staging register follows the merged value.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '0;
        else        stage <= stage_nxt;
    end

    // Live count: commit has priority over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= stage;
        else if (tick && count_en) cnt <= cnt + 1'b1;
    end

    // R7
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(stage)));
    // R2 R8
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && count_en) |=> (cnt == $past(cnt) + 1'b1));
    // R2
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/sc_reg_port.sv
// Module: sc_reg_port
// Register read path, read snapshot and control register.
// Assumes: wr is already qualified by the frame select.
module sc_reg_port #(
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 3,
    parameter int CTRL_ADDR = 4,
    parameter int STOP_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  sc_pkg::byte_t     wdata,
    input  logic [CNT_W-1:0]  cnt,
    output sc_pkg::byte_t     rdata,
    output logic              stop
);
    localparam int NBYTES = CNT_W / 8;

    logic [CNT_W-1:0] snap;
    sc_pkg::byte_t    rdata_nxt;

    // Select the byte a read returns: live low byte, snapshot bytes, or control.
    always_comb begin
        rdata_nxt = '0;
        if (addr == '0) rdata_nxt = cnt[7:0];
        for (int i = 1; i < NBYTES; i++) begin
            if (addr == ADDR_W'(i)) rdata_nxt = snap[8*i +: 8];
        end
        if (addr == ADDR_W'(CTRL_ADDR)) begin
            rdata_nxt           = '0;
            rdata_nxt[STOP_BIT] = stop;
        end
    end

    // Capture read data and take the snapshot on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            snap  <= '0;
        end else if (rd) begin
            rdata <= rdata_nxt;
            if (addr == '0) snap <= cnt;
        end
    end

    // Control register: only the stop bit is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  stop <= 1'b0;
        else if (wr && addr == ADDR_W'(CTRL_ADDR))   stop <= wdata[STOP_BIT];
    end

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
    // R6
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == '0) |=> (rdata == $past(cnt[7:0])));
endmodule

// File: rtl/sec_counter_top.sv
// Module: sec_counter_top
// Seconds counter with a byte register port and power-mode-dependent stop.
// Assumes: clk is the 32.768 kHz timebase.
module sec_counter_top #(
    parameter int CNT_W     = sc_pkg::DEF_CNT_W,
    parameter int PRE_W     = sc_pkg::DEF_PRE_W,
    parameter int ADDR_W    = sc_pkg::DEF_ADDR_W,
    parameter int CTRL_ADDR = sc_pkg::DEF_CTRL_ADDR,
    parameter int STOP_BIT  = sc_pkg::DEF_STOP_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              backup_mode,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              osc_run,
    output logic              standby
);
    logic             stop;
    logic             tick;
    logic             load;
    logic             wr_q;
    logic [CNT_W-1:0] cnt;

    assign wr_q    = reg_wr && reg_sel;
    assign standby = backup_mode && stop;
    assign osc_run = !standby;

    sc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(osc_run), .clr(load), .tick(tick)
    );

    sc_count_core #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count_en(!stop),
        .sel(reg_sel), .wr(wr_q), .addr(reg_addr), .wdata(reg_wdata),
        .cnt(cnt), .load(load)
    );

    sc_reg_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
                  .STOP_BIT(STOP_BIT)) u_port (
        .clk(clk), .rst_n(rst_n), .rd(reg_rd), .wr(wr_q), .addr(reg_addr),
        .wdata(reg_wdata), .cnt(cnt), .rdata(reg_rdata), .stop(stop)
    );

    // R3
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load) |=> $stable(cnt));
endmodule

// File: tb/sec_counter_top_tb.sv
module sec_counter_top_tb;
    localparam int PRE_W = 4;
    localparam int SEC   = 1 << PRE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic backup_mode = 1'b0;
    logic reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic osc_run, standby;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sec_counter_top #(.PRE_W(PRE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .backup_mode(backup_mode),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .osc_run(osc_run), .standby(standby)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wbyte(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // Full load; returns just after the commit edge.
    task automatic load32(input logic [31:0] v);
        @(negedge clk); reg_sel = 1'b1;
        for (int i = 0; i < 4; i++) wbyte(3'(i), v[8*i +: 8]);
        reg_sel = 1'b0;
        @(posedge clk);
    endtask

    task automatic ctrl_wr(input logic [7:0] d);
        @(negedge clk); reg_sel = 1'b1;
        wbyte(3'd4, d);
        reg_sel = 1'b0;
    endtask

    task automatic rd_byte(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic rd32(output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd_byte(3'(i), b);
            v[8*i +: 8] = b;
        end
    endtask

    // Low-byte read captured at load edge + m (m >= 1).
    task automatic rd32_at(input int m, output logic [31:0] v);
        repeat (m - 1) @(negedge clk);
        rd32(v);
    endtask

    initial begin
        logic [31:0] v, expv;
        logic [7:0] b;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        check("R1 rdata after reset", {24'h0, reg_rdata}, 32'h0);
        check("R4 osc_run main power", {31'h0, osc_run}, 32'h1);
        check("R4 standby main power", {31'h0, standby}, 32'h0);
        rd_byte(3'd4, b); check("R1 control reset", {24'h0, b}, 32'h0);
        rd32(v); check("R1 count reset", v, 32'h0);

        // R2 tick timing after load; R5 byte order via load/read round trip
        load32(32'hA1B2C3D4); rd32_at(SEC, v);
        check("R2 R5 no tick before period", v, 32'hA1B2C3D4);
        load32(32'hA1B2C3D4); rd32_at(SEC + 1, v);
        check("R2 first tick", v, 32'hA1B2C3D5);
        load32(32'h00000010); rd32_at(3 * SEC + 1, v);
        check("R2 three ticks", v, 32'h00000013);

        // R6 coherent read across a carry
        load32(32'h12FFFFFF); rd32_at(SEC, v);
        check("R6 snapshot across carry", v, 32'h12FFFFFF);
        rd32(v); check("R6 live count after carry", v, 32'h13000000);

        // R8 wrap
        load32(32'hFFFFFFFF); rd32_at(SEC + 1, v);
        check("R8 wrap to zero", v, 32'h0);

        // R3 stop bit on main power
        ctrl_wr(8'hFF); rd_byte(3'd4, b);
        check("R3 control reads stop bit only", {24'h0, b}, 32'h80);
        check("R4 timebase runs when stopped on main power", {31'h0, osc_run}, 32'h1);
        load32(32'h01020304); rd32_at(5 * SEC, v);
        check("R3 count frozen", v, 32'h01020304);

        // R4 backup mode
        @(negedge clk); backup_mode = 1'b1; #1;
        check("R4 osc_run backup stopped", {31'h0, osc_run}, 32'h0);
        check("R4 standby backup stopped", {31'h0, standby}, 32'h1);
        load32(32'h55667788); rd32_at(4 * SEC, v);
        check("R4 frozen in standby", v, 32'h55667788);
        ctrl_wr(8'h00); #1;
        check("R4 osc_run backup enabled", {31'h0, osc_run}, 32'h1);
        load32(32'h55667788); rd32_at(SEC + 1, v);
        check("R4 counts in backup when enabled", v, 32'h55667789);
        @(negedge clk); backup_mode = 1'b0;
        ctrl_wr(8'h80);

        // R7 staging invisible until frame end, partial write
        load32(32'hCAFE0000);
        @(negedge clk); reg_sel = 1'b1;
        wbyte(3'd2, 8'hAB);
        rd32(v); check("R7 staged byte not yet visible", v, 32'hCAFE0000);
        reg_sel = 1'b0; @(posedge clk);
        rd32(v); check("R7 partial commit", v, 32'hCAAB0000);

        // R7 writes outside a frame ignored
        @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h00;
        @(negedge clk); reg_wr = 1'b0;
        rd_byte(3'd4, b); check("R7 control write without frame ignored", {24'h0, b}, 32'h80);

        // R9 unmapped addresses and read hold
        for (int a = 5; a < 8; a++) begin
            rd_byte(3'(a), b); check("R9 unmapped reads zero", {24'h0, b}, 32'h0);
        end
        @(negedge clk); reg_sel = 1'b1;
        wbyte(3'd6, 8'hFF);
        reg_sel = 1'b0; @(posedge clk);
        rd32(v); check("R9 unmapped write ignored", v, 32'hCAAB0000);
        rd_byte(3'd4, b); check("R9 unmapped write leaves control", {24'h0, b}, 32'h80);
        repeat (5) @(negedge clk);
        check("R9 rdata holds between strobes", {24'h0, reg_rdata}, 32'h80);

        // R5 R7 lane sweep against an arithmetic model (counting stopped)
        expv = 32'hCAAB0000;
        for (int lane = 0; lane < 4; lane++) begin
            for (int k = 0; k < 8; k++) begin
                logic [7:0] d;
                d = 8'((lane * 37 + k * 29 + 1) ^ (k << 5));
                @(negedge clk); reg_sel = 1'b1;
                wbyte(3'(lane), d);
                reg_sel = 1'b0; @(posedge clk);
                expv[8*lane +: 8] = d;
                rd32(v); check("R5 R7 lane sweep", v, expv);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule